// File: doc/BRIEF.md
# Credit-Based Interrupt Moderator

This block decides when each descriptor ring should raise a completion interrupt. Every ring keeps a count of descriptors that hardware has completed and software has not yet consumed. Hardware pulses a per-ring completion line for each finished descriptor. Software hands credits back by writing a ring index and an amount. The block emits at most one interrupt request per cycle, as a single-cycle strobe carrying a vector number. A downstream message-signalled interrupt sender consumes that strobe.

After a ring fires, further completions on it stay silent until software responds, because each ring masks itself. A response that clears the whole count only lifts that mask. A response that leaves work outstanding keeps the mask and fires again, so software comes back for the rest. This self-mask has nothing to do with any per-vector mask held in the downstream vector table. The credit count of any ring can be read through a ring-select input, and the self-mask and a sticky over-return flag of every ring are visible as bit vectors.

Top module: `credit_irq_mod`

## Requirements
- R1: A completion pulse on a ring raises that ring's credit count by one. The new count is readable on rd_credit in the cycle after the clock edge that sampled the pulse.
- R2: A completion that takes a ring's count from zero to non-zero sets that ring's mask bit and produces exactly one interrupt. Further completions while the count is non-zero produce none.
- R3: A credit return (ret_valid with ret_ring and ret_credits) subtracts ret_credits from the selected ring's count. Other rings are unaffected.
- R4: A return that brings the count to exactly zero clears the ring's mask bit and produces no interrupt.
- R5: A return that leaves the count non-zero keeps the mask bit set and produces one interrupt for that ring. This includes a return of zero credits.
- R6: Ring 0 maps to vector 0, ring 1 to vector 1, and ring r of 2 or more to vector r+2. Ring indices map to even and odd vectors from 4 upward. Vectors 2 and 3 are never issued.
- R7: A return larger than the count sets the count to zero, sets the ring's err_o bit, clears its mask bit and fires nothing. err_o bits are cleared only by reset.
- R8: A completion and a return on the same ring in one cycle are both applied: count + 1 - returned. The fire-or-unmask decision follows R4/R5/R7 on that resulting count.
- R9: A fire decision recorded at a clock edge leaves the ring pending. Pending rings are issued one per cycle, on irq_valid/irq_vector, in round-robin order starting after the last ring issued; ring 0 is first after reset. A request never issued stays pending. Repeated fires of a pending ring merge.
- R10: The count saturates at 2^CREDIT_W-1 and does not wrap.
- R11: After reset all counts, mask bits, err bits and irq_valid are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | NUM_RINGS | Per-ring descriptor completion pulse |
| ret_valid | input | 1 | Credit return write strobe |
| ret_ring | input | $clog2(NUM_RINGS) | Ring receiving the returned credits |
| ret_credits | input | CREDIT_W | Number of credits returned |
| rd_ring | input | $clog2(NUM_RINGS) | Ring whose count appears on rd_credit |
| rd_credit | output | CREDIT_W | Credit count of rd_ring |
| mask_o | output | NUM_RINGS | Per-ring self-mask bits |
| err_o | output | NUM_RINGS | Per-ring sticky over-return flags |
| irq_valid | output | 1 | Interrupt request strobe |
| irq_vector | output | VEC_W | Vector number of the request |

## Verification
The bench targets several corner cases:
- A full return must unmask silently. A design that fires on it would flood software with empty interrupts.
- A partial return, and a return of zero, must fire again. Missing this leaves work stranded behind the mask forever.
- A completion colliding with a return on one ring must net both. A design that drops either one drifts its count and misjudges the fire decision.
- An over-return must floor the count at zero and latch the flag rather than wrapping to a huge count.
- Several rings firing together must all be issued, one per cycle, in rotating order. A lost pending bit or a fixed priority shows up as a missing or reordered vector against the bench's cycle model.

// File: rtl/credit_irq_mod.sv
module credit_irq_mod #(
  parameter int NUM_RINGS = 8,
  parameter int CREDIT_W  = 16,
  parameter int VEC_W     = 8,
  localparam int RING_W   = $clog2(NUM_RINGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RINGS-1:0] done_i,
  input  logic                 ret_valid,
  input  logic [RING_W-1:0]    ret_ring,
  input  logic [CREDIT_W-1:0]  ret_credits,
  input  logic [RING_W-1:0]    rd_ring,
  output logic [CREDIT_W-1:0]  rd_credit,
  output logic [NUM_RINGS-1:0] mask_o,
  output logic [NUM_RINGS-1:0] err_o,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector
);
  localparam logic [CREDIT_W:0] CNT_MAX = {1'b0, {CREDIT_W{1'b1}}};

  logic [CREDIT_W-1:0] cnt_q   [NUM_RINGS];
  logic [CREDIT_W-1:0] cnt_nxt [NUM_RINGS];
  logic [NUM_RINGS-1:0] pend_q, fire, under, zero_nxt;
  logic [RING_W-1:0] last_q, gnt_idx;
  logic gnt_any;

  function automatic logic [VEC_W-1:0] ring_vec(input logic [RING_W-1:0] r);
    return (int'(r) < 2) ? VEC_W'(r) : VEC_W'(r) + VEC_W'(2);
  endfunction

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    logic hit;
    logic [CREDIT_W:0] sum, sub, diff;
    assign hit  = ret_valid && (ret_ring == RING_W'(g));
    assign sum  = {1'b0, cnt_q[g]} + {{CREDIT_W{1'b0}}, done_i[g]};
    assign sub  = hit ? {1'b0, ret_credits} : '0;
    assign under[g] = sub > sum;
    assign diff = sum - sub;
    assign cnt_nxt[g] = under[g] ? '0 : (diff > CNT_MAX) ? CNT_MAX[CREDIT_W-1:0] : diff[CREDIT_W-1:0];
    assign zero_nxt[g] = (cnt_nxt[g] == '0);
    assign fire[g] = !zero_nxt[g] && (hit || (done_i[g] && cnt_q[g] == '0));
  end

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= NUM_RINGS; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NUM_RINGS;
      if (!gnt_any && pend_q[idx]) begin
        gnt_any = 1'b1;
        gnt_idx = RING_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RINGS; i++) cnt_q[i] <= '0;
      mask_o     <= '0;
      err_o      <= '0;
      pend_q     <= '0;
      last_q     <= RING_W'(NUM_RINGS - 1);
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      for (int i = 0; i < NUM_RINGS; i++) begin
        cnt_q[i] <= cnt_nxt[i];
        if (fire[i])          mask_o[i] <= 1'b1;
        else if (zero_nxt[i]) mask_o[i] <= 1'b0;
      end
      err_o     <= err_o | under;
      irq_valid <= gnt_any;
      if (gnt_any) begin
        irq_vector <= ring_vec(gnt_idx);
        last_q     <= gnt_idx;
      end
      pend_q <= (pend_q & ~(gnt_any ? (NUM_RINGS'(1) << gnt_idx) : '0)) | fire;
    end
  end

  assign rd_credit = cnt_q[rd_ring];
endmodule

// File: rtl/credit_irq_mod_chk.sv
module credit_irq_mod_chk #(
  parameter int NUM_RINGS = 8,
  parameter int CREDIT_W  = 16,
  parameter int VEC_W     = 8,
  parameter int RING_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [RING_W-1:0]    rd_ring,
  input logic [CREDIT_W-1:0]  rd_credit,
  input logic [NUM_RINGS-1:0] mask_o,
  input logic [NUM_RINGS-1:0] err_o,
  input logic [NUM_RINGS-1:0] pend_q,
  input logic [NUM_RINGS-1:0] fire,
  input logic                 irq_valid,
  input logic [VEC_W-1:0]     irq_vector
);
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector != VEC_W'(2) && irq_vector != VEC_W'(3) && int'(irq_vector) < NUM_RINGS + 2)); // R6

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |=> !irq_valid); // R9

  AST_ZERO_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_credit == '0) |-> !mask_o[rd_ring]); // R4

  AST_NONZERO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_credit != '0) |-> mask_o[rd_ring]); // R2

  for (genvar i = 0; i < NUM_RINGS; i++) begin : g_chk
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_o[i] |=> err_o[i]); // R7
    AST_FIRE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> (mask_o[i] && pend_q[i])); // R9
  end
endmodule

bind credit_irq_mod credit_irq_mod_chk #(
  .NUM_RINGS(NUM_RINGS), .CREDIT_W(CREDIT_W), .VEC_W(VEC_W), .RING_W(RING_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ring(rd_ring), .rd_credit(rd_credit),
  .mask_o(mask_o), .err_o(err_o), .pend_q(pend_q), .fire(fire),
  .irq_valid(irq_valid), .irq_vector(irq_vector)
);

// File: tb/tb_credit_irq_mod.sv
module tb_credit_irq_mod;
  localparam int N  = 8;
  localparam int CW = 6;
  localparam int VW = 8;
  localparam int RW = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] done_i = '0;
  logic ret_valid = 0;
  logic [RW-1:0] ret_ring = '0, rd_ring = '0;
  logic [CW-1:0] ret_credits = '0;
  logic [CW-1:0] rd_credit;
  logic [N-1:0] mask_o, err_o;
  logic irq_valid;
  logic [VW-1:0] irq_vector;

  credit_irq_mod #(.NUM_RINGS(N), .CREDIT_W(CW), .VEC_W(VW)) dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .ret_valid(ret_valid),
    .ret_ring(ret_ring), .ret_credits(ret_credits), .rd_ring(rd_ring),
    .rd_credit(rd_credit), .mask_o(mask_o), .err_o(err_o),
    .irq_valid(irq_valid), .irq_vector(irq_vector));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_cnt[N];
  bit m_mask[N], m_err[N], m_pend[N];
  int m_last = N - 1;
  bit m_irq = 0;
  int m_vec = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [N-1:0] d, input bit rv, input int rr, input int rc);
    int g;
    g = -1;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_last + k) % N;
      if (g < 0 && m_pend[idx]) g = idx;
    end
    m_irq = (g >= 0);
    if (g >= 0) begin
      m_vec = (g < 2) ? g : g + 2;
      m_last = g;
      m_pend[g] = 0;
    end
    for (int i = 0; i < N; i++) begin
      bit hit, f;
      int t, was;
      hit = rv && (rr == i);
      was = m_cnt[i];
      t = was + int'(d[i]) - (hit ? rc : 0);
      if (t < 0) begin m_err[i] = 1; t = 0; end
      if (t > MAXC) t = MAXC;
      f = (t != 0) && (hit || (d[i] && was == 0));
      if (f) begin m_mask[i] = 1; m_pend[i] = 1; end
      else if (t == 0) m_mask[i] = 0;
      m_cnt[i] = t;
    end
  endtask

  task automatic compare();
    logic [N-1:0] em, ee;
    for (int i = 0; i < N; i++) begin em[i] = m_mask[i]; ee[i] = m_err[i]; end
    chk(int'(rd_credit) == m_cnt[rd_ring], "R1 R3 count", int'(rd_credit), m_cnt[rd_ring]);
    chk(mask_o == em, "R4 R5 mask", int'(mask_o), int'(em));
    chk(err_o == ee, "R7 err", int'(err_o), int'(ee));
    chk(irq_valid == m_irq, "R9 irq_valid", int'(irq_valid), int'(m_irq));
    if (m_irq) chk(int'(irq_vector) == m_vec, "R6 irq_vector", int'(irq_vector), m_vec);
  endtask

  task automatic step(input logic [N-1:0] d, input bit rv, input int rr, input int rc, input int rd);
    done_i = d; ret_valid = rv; ret_ring = RW'(rr); ret_credits = CW'(rc); rd_ring = RW'(rd);
    @(posedge clk);
    model_edge(d, rv, rr, rc);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int rd);
    step('0, 0, 0, 0, rd);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_mask[i] = 0; m_err[i] = 0; m_pend[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(irq_valid == 0 && mask_o == 0 && err_o == 0 && rd_credit == 0, "R11 reset", int'(mask_o), 0);

    step(8'h08, 0, 0, 0, 3);
    chk(rd_credit == 1, "R1 first completion", int'(rd_credit), 1);
    chk(mask_o[3] == 1 && irq_valid == 0, "R2 masked, not yet issued", int'(irq_valid), 0);
    idle(3);
    chk(irq_valid == 1 && irq_vector == 5, "R6 ring3 vector", int'(irq_vector), 5);
    idle(3);
    chk(irq_valid == 0, "R2 single interrupt", int'(irq_valid), 0);
    step(8'h08, 0, 0, 0, 3);
    idle(3);
    chk(irq_valid == 0 && rd_credit == 2, "R2 silent while masked", int'(irq_valid), 0);

    step('0, 1, 3, 1, 3);
    chk(rd_credit == 1 && mask_o[3] == 1, "R3 R5 partial return", int'(rd_credit), 1);
    idle(3);
    chk(irq_valid == 1 && irq_vector == 5, "R5 refire", int'(irq_valid), 1);
    step('0, 1, 3, 1, 3);
    chk(rd_credit == 0 && mask_o[3] == 0, "R4 full return unmasks", int'(mask_o[3]), 0);
    idle(3);
    chk(irq_valid == 0, "R4 no interrupt", int'(irq_valid), 0);

    step(8'h10, 0, 0, 0, 4);
    idle(4);
    chk(irq_valid == 1 && irq_vector == 6, "R6 ring4 vector", int'(irq_vector), 6);
    step('0, 1, 4, 5, 4);
    chk(rd_credit == 0 && err_o[4] == 1 && mask_o[4] == 0, "R7 over-return", int'(err_o), 8'h10);
    idle(4);
    chk(irq_valid == 0 && err_o[4] == 1, "R7 silent and sticky", int'(irq_valid), 0);

    step(8'h04, 1, 2, 0, 2);
    chk(rd_credit == 1 && mask_o[2] == 1, "R8 collide from zero", int'(rd_credit), 1);
    idle(2);
    chk(irq_valid == 1 && irq_vector == 4, "R8 R6 ring2 fires", int'(irq_vector), 4);
    step(8'h04, 1, 2, 2, 2);
    chk(rd_credit == 0 && mask_o[2] == 0, "R8 collide to zero", int'(rd_credit), 0);
    idle(2);
    chk(irq_valid == 0, "R8 no interrupt at zero", int'(irq_valid), 0);

    step(8'hA3, 0, 0, 0, 0);
    seen = '0;
    for (int k = 0; k < 4; k++) begin
      idle(0);
      chk(irq_valid == 1, "R9 back-to-back issue", int'(irq_valid), 1);
      seen[irq_vector[3:0]] = 1'b1;
    end
    chk(seen == 16'h0283, "R9 all pending issued", int'(seen), 16'h0283);
    idle(0);
    chk(irq_valid == 0, "R9 queue drained", int'(irq_valid), 0);
    for (int r = 0; r < N; r++) if (m_cnt[r] != 0) step('0, 1, r, m_cnt[r], r);
    idle(0); idle(0);

    for (int k = 0; k < MAXC + 6; k++) step(8'h40, 0, 0, 0, 6);
    chk(rd_credit == CW'(MAXC), "R10 saturate", int'(rd_credit), MAXC);
    step('0, 1, 6, MAXC, 6);
    chk(rd_credit == 0, "R3 drain", int'(rd_credit), 0);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] d;
      bit rv;
      int rc;
      d = N'($urandom & $urandom & $urandom);
      rv = ($urandom % 3) == 0;
      rc = (($urandom % 8) == 0) ? int'($urandom % 16) : int'($urandom % 3);
      step(d, rv, int'($urandom % N), rc, int'($urandom % N));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule